// File: doc/BRIEF.md
# Trigger latency pipeline with derandomizing event buffers

This block sits behind the per-channel baseline correction of a front-end readout. Every sample strobe, one corrected sample for each channel is written into a circular delay ring. A read tap trails the write position by a fixed latency, so the ring presents each sample again exactly that many strobes after it arrived. The latency matches the time the trigger system needs to decide.

An accepted level-one pulse starts a capture on the next strobe. The capture copies a window of delayed samples for every channel into the next free event buffer, one window word per strobe. A small queue of such buffers absorbs random trigger arrival. A downstream reader drains completed events in the order they were accepted, channel by channel, with a valid/ready handshake. Each word carries its channel and sample tags, and the last word of each event is flagged.

Busy is raised while a capture is running or while every buffer is full. An accept that arrives while busy is raised is counted and has no other effect. A synchronous initialize pulse empties the whole pipeline.

Top module: `trig_latency_pipe`

## Requirements
- R1: On each strobe with `smp_en_i` high, the ring stores `smp_data_i`. The value the ring presents on that strobe is the sample of the same channel from exactly LAT strobes earlier, counted from the last initialize.
- R2: Consider an accepted `l1a_i` pulse, and let n0 be the index of the first strobe after it. Word k (k = 0..WIN-1) of channel c of that event is the channel c sample from strobe n0+k-LAT. Channel c occupies bits [c*SW +: SW] of `smp_data_i`.
- R3: Readout is channel-major: all WIN samples of channel 0 come first, then channel 1, and so on. `rd_ch_o` and `rd_smp_o` give the channel and sample index of the current word. `rd_last_o` is high only on the word with channel NCH-1 and sample WIN-1.
- R4: Up to NBUF completed events are held. They are read out in accept order. An event's buffer is released at the handshake of its last word.
- R5: `busy_o` is high from the cycle after an accepted pulse until the edge of the WIN-th capture strobe. It is also high whenever NBUF completed events are held.
- R6: An `l1a_i` pulse seen while `busy_o` is high increments `drop_cnt_o` by one. It leaves every stored and in-progress event unchanged.
- R7: A one-cycle `init_i` empties all buffers, aborts any capture, clears `drop_cnt_o` and restarts the ring's write position.
- R8: After reset, `rd_vld_o` and `busy_o` are low and `drop_cnt_o` is zero.
- R9: `rd_vld_o` is high exactly while at least one completed event is held. While `rd_rdy_i` is low, the presented word and its tags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_i | input | 1 | Synchronous pipeline initialize pulse |
| smp_en_i | input | 1 | Sample strobe, one cycle per sample period |
| smp_data_i | input | NCH*SW | One corrected sample per channel, channel c at [c*SW +: SW] |
| l1a_i | input | 1 | Level-one accept pulse |
| rd_rdy_i | input | 1 | Reader ready |
| rd_vld_o | output | 1 | Readout word valid |
| rd_data_o | output | SW | Readout sample |
| rd_ch_o | output | clog2(NCH) | Channel tag of the readout word |
| rd_smp_o | output | clog2(WIN) | Sample tag of the readout word |
| rd_last_o | output | 1 | Final word of the event |
| busy_o | output | 1 | No further accept can be taken |
| drop_cnt_o | output | DCW | Count of accepts ignored while busy |

## Verification
Busy rises in the first cycle after the edge that sees an accepted pulse. A completed event becomes valid right after the edge of its WIN-th capture strobe. The bench samples both busy and valid on the falling edge that follows those edges. Readout words come straight from registered pointers, so each word is compared on the falling edge before the handshake edge that advances it. Buffer release is checked one falling edge after the last word's handshake. The drop count is read on the falling edge right after the ignored pulse's edge. Accept phases are swept over every ring position, and each expected sample is computed arithmetically from its strobe index.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_RUN   = 2'd2
  } cap_state_e;

  // linear position of (block, row, col) in a block/row/col ordered store
  function automatic int unsigned flat_index(int unsigned blk, int unsigned row,
                                             int unsigned col, int unsigned nrow,
                                             int unsigned ncol);
    return (blk * nrow + row) * ncol + col;
  endfunction

endpackage

// File: rtl/tlp_delay_ring.sv
module tlp_delay_ring #(
  parameter int NCH   = 2,
  parameter int SW    = 12,
  parameter int DEPTH = 160,
  parameter int LAT   = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              smp_en,
  input  logic [NCH*SW-1:0] din,
  output logic [NCH*SW-1:0] dly
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] LAT_V = (PW+1)'(LAT);
  localparam logic [PW:0] OFF_V = (PW+1)'(DEPTH - LAT);

  logic [NCH*SW-1:0] ring [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp;

  always_comb begin
    wp_d = wp_q;
    if (init) begin
      wp_d = '0;
    end else if (smp_en) begin
      wp_d = (32'(wp_q) == DEPTH - 1) ? '0 : wp_q + 1'b1;
    end
  end

  // tap trails the write position by LAT entries, modulo DEPTH
  always_comb begin
    if ({1'b0, wp_q} >= LAT_V) rp = PW'({1'b0, wp_q} - LAT_V);
    else                       rp = PW'({1'b0, wp_q} + OFF_V);
  end

  assign dly = ring[rp];

  always_ff @(posedge clk) begin
    if (smp_en) ring[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_d;
  end

  AST_RING_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wp_q) < DEPTH) && (32'(rp) < DEPTH)); // R1

endmodule

// File: rtl/tlp_capture_ctrl.sv
module tlp_capture_ctrl
  import tlp_pkg::*;
#(
  parameter int NBUF = 5,
  parameter int WIN  = 160,
  parameter int DCW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init,
  input  logic                     smp_en,
  input  logic                     acc,
  input  logic                     pop_done,
  output logic                     wr_en,
  output logic [$clog2(NBUF)-1:0]  wr_buf,
  output logic [$clog2(WIN)-1:0]   wr_idx,
  output logic                     avail,
  output logic                     busy,
  output logic [DCW-1:0]           drop_cnt
);
  localparam int BW = $clog2(NBUF);
  localparam int KW = $clog2(WIN);
  localparam int CW = $clog2(NBUF + 1);

  cap_state_e     st_q, st_d;
  logic [KW-1:0]  k_q, k_d;
  logic [BW-1:0]  wb_q, wb_d;
  logic [CW-1:0]  occ_q, occ_d;
  logic [DCW-1:0] drop_q, drop_d;
  logic           ev_done;

  assign busy     = (st_q != CAP_IDLE) || (occ_q == CW'(NBUF));
  assign avail    = (occ_q != '0);
  assign wr_en    = smp_en && (st_q != CAP_IDLE);
  assign wr_buf   = wb_q;
  assign wr_idx   = k_q;
  assign drop_cnt = drop_q;

  always_comb begin
    st_d    = st_q;
    k_d     = k_q;
    wb_d    = wb_q;
    drop_d  = drop_q;
    ev_done = 1'b0;
    if (acc) begin
      if (busy) drop_d = drop_q + 1'b1;
      else      st_d   = CAP_ARMED;
    end
    if (wr_en) begin
      if (k_q == KW'(WIN - 1)) begin
        ev_done = 1'b1;
        st_d    = CAP_IDLE;
        k_d     = '0;
        wb_d    = (wb_q == BW'(NBUF - 1)) ? '0 : wb_q + 1'b1;
      end else begin
        st_d = CAP_RUN;
        k_d  = k_q + 1'b1;
      end
    end
    case ({ev_done, pop_done})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
    if (init) begin
      st_d   = CAP_IDLE;
      k_d    = '0;
      wb_d   = '0;
      occ_d  = '0;
      drop_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAP_IDLE;
      k_q    <= '0;
      wb_q   <= '0;
      occ_q  <= '0;
      drop_q <= '0;
    end else begin
      st_q   <= st_d;
      k_q    <= k_d;
      wb_q   <= wb_d;
      occ_q  <= occ_d;
      drop_q <= drop_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_q) <= NBUF); // R4
  AST_POP_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done |-> (occ_q != '0)); // R4
  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !busy && !init) |=> busy); // R5
  AST_DROP_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && busy && (st_q == CAP_IDLE)) |=> (st_q == CAP_IDLE)); // R6

endmodule

// File: rtl/tlp_event_store.sv
module tlp_event_store
  import tlp_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int SW   = 12,
  parameter int WIN  = 160,
  parameter int NBUF = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init,
  input  logic                    wr_en,
  input  logic [$clog2(NBUF)-1:0] wr_buf,
  input  logic [$clog2(WIN)-1:0]  wr_idx,
  input  logic [NCH*SW-1:0]       wr_data,
  input  logic                    avail,
  input  logic                    rd_rdy,
  output logic                    rd_vld,
  output logic [SW-1:0]           rd_data,
  output logic [$clog2(NCH)-1:0]  rd_ch,
  output logic [$clog2(WIN)-1:0]  rd_smp,
  output logic                    rd_last,
  output logic                    pop_done
);
  localparam int BW    = $clog2(NBUF);
  localparam int KW    = $clog2(WIN);
  localparam int CHW   = $clog2(NCH);
  localparam int WORDS = NBUF * NCH * WIN;
  localparam int AW    = $clog2(WORDS);

  logic [SW-1:0]  mem [WORDS];
  logic [BW-1:0]  rb_q, rb_d;
  logic [CHW-1:0] rc_q, rc_d;
  logic [KW-1:0]  rs_q, rs_d;
  logic           fire;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int c = 0; c < NCH; c++) begin
        mem[AW'(flat_index(32'(wr_buf), c, 32'(wr_idx), NCH, WIN))] <= wr_data[c*SW +: SW];
      end
    end
  end

  assign rd_vld   = avail;
  assign rd_data  = mem[AW'(flat_index(32'(rb_q), 32'(rc_q), 32'(rs_q), NCH, WIN))];
  assign rd_ch    = rc_q;
  assign rd_smp   = rs_q;
  assign rd_last  = (rc_q == CHW'(NCH - 1)) && (rs_q == KW'(WIN - 1));
  assign fire     = rd_vld && rd_rdy;
  assign pop_done = fire && rd_last;

  always_comb begin
    rb_d = rb_q;
    rc_d = rc_q;
    rs_d = rs_q;
    if (fire) begin
      if (rs_q == KW'(WIN - 1)) begin
        rs_d = '0;
        if (rc_q == CHW'(NCH - 1)) begin
          rc_d = '0;
          rb_d = (rb_q == BW'(NBUF - 1)) ? '0 : rb_q + 1'b1;
        end else begin
          rc_d = rc_q + 1'b1;
        end
      end else begin
        rs_d = rs_q + 1'b1;
      end
    end
    if (init) begin
      rb_d = '0;
      rc_d = '0;
      rs_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= '0;
      rc_q <= '0;
      rs_q <= '0;
    end else begin
      rb_q <= rb_d;
      rc_q <= rc_d;
      rs_q <= rs_d;
    end
  end

  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rd_last && !init) |=>
      ((rd_ch == $past(rd_ch) && rd_smp == $past(rd_smp) + 1'b1) ||
       (rd_ch == $past(rd_ch) + 1'b1 && rd_smp == '0))); // R3
  AST_NO_WRITE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && avail) |-> (wr_buf != rb_q)); // R6

endmodule

// File: rtl/trig_latency_pipe.sv
module trig_latency_pipe #(
  parameter int NCH   = 2,
  parameter int SW    = 12,
  parameter int DEPTH = 160,
  parameter int LAT   = 160,
  parameter int WIN   = 160,
  parameter int NBUF  = 5,
  parameter int DCW   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    init_i,
  input  logic                    smp_en_i,
  input  logic [NCH*SW-1:0]       smp_data_i,
  input  logic                    l1a_i,
  input  logic                    rd_rdy_i,
  output logic                    rd_vld_o,
  output logic [SW-1:0]           rd_data_o,
  output logic [$clog2(NCH)-1:0]  rd_ch_o,
  output logic [$clog2(WIN)-1:0]  rd_smp_o,
  output logic                    rd_last_o,
  output logic                    busy_o,
  output logic [DCW-1:0]          drop_cnt_o
);
  localparam int BW = $clog2(NBUF);
  localparam int KW = $clog2(WIN);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [NCH*SW-1:0] dly;
  logic              wr_en, avail, pop_done;
  logic [BW-1:0]     wr_buf;
  logic [KW-1:0]     wr_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tlp_delay_ring #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH), .LAT(LAT)) i_ring (
    .clk(clk_i), .rst_n(rst_n), .init(init_i), .smp_en(smp_en_i),
    .din(smp_data_i), .dly(dly)
  );

  tlp_capture_ctrl #(.NBUF(NBUF), .WIN(WIN), .DCW(DCW)) i_ctrl (
    .clk(clk_i), .rst_n(rst_n), .init(init_i), .smp_en(smp_en_i),
    .acc(l1a_i), .pop_done(pop_done), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_idx(wr_idx), .avail(avail), .busy(busy_o), .drop_cnt(drop_cnt_o)
  );

  tlp_event_store #(.NCH(NCH), .SW(SW), .WIN(WIN), .NBUF(NBUF)) i_store (
    .clk(clk_i), .rst_n(rst_n), .init(init_i), .wr_en(wr_en),
    .wr_buf(wr_buf), .wr_idx(wr_idx), .wr_data(dly), .avail(avail),
    .rd_rdy(rd_rdy_i), .rd_vld(rd_vld_o), .rd_data(rd_data_o),
    .rd_ch(rd_ch_o), .rd_smp(rd_smp_o), .rd_last(rd_last_o),
    .pop_done(pop_done)
  );

endmodule

// File: tb/test_trig_latency_pipe.sv
module test_trig_latency_pipe;
  localparam int NCH = 2, SW = 12, DEPTH = 8, LAT = 6, WIN = 5, NBUF = 3, DCW = 8;

  logic clk = 1'b0;
  logic rst_ni, init_i, smp_en_i, l1a_i, rd_rdy_i;
  logic [NCH*SW-1:0] smp_data_i;
  logic rd_vld_o, rd_last_o, busy_o;
  logic [SW-1:0] rd_data_o;
  logic [$clog2(NCH)-1:0] rd_ch_o;
  logic [$clog2(WIN)-1:0] rd_smp_o;
  logic [DCW-1:0] drop_cnt_o;

  int checks = 0, errors = 0, n = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trig_latency_pipe #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH), .LAT(LAT), .WIN(WIN),
                      .NBUF(NBUF), .DCW(DCW)) i_trig_latency_pipe (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .smp_en_i(smp_en_i),
    .smp_data_i(smp_data_i), .l1a_i(l1a_i), .rd_rdy_i(rd_rdy_i),
    .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o), .rd_ch_o(rd_ch_o),
    .rd_smp_o(rd_smp_o), .rd_last_o(rd_last_o), .busy_o(busy_o),
    .drop_cnt_o(drop_cnt_o)
  );

  function automatic int xval(int idx, int c);
    return (idx * 37 + c * 501 + 3) % 4096;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // starts and ends on a falling edge; one strobe every three cycles
  task automatic strobe();
    for (int c = 0; c < NCH; c++) smp_data_i[c*SW +: SW] = SW'(xval(n, c));
    smp_en_i = 1'b1;
    @(negedge clk);
    smp_en_i = 1'b0;
    n++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic strobes(int cnt);
    for (int i = 0; i < cnt; i++) strobe();
  endtask

  task automatic accept();
    l1a_i = 1'b1;
    @(negedge clk);
    l1a_i = 1'b0;
  endtask

  task automatic read_event(int n0, string tag);
    rd_rdy_i = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < WIN; k++) begin
        int exp_d;
        bit exp_l;
        exp_d = xval(n0 + k - LAT, c);
        exp_l = (c == NCH - 1) && (k == WIN - 1);
        chk(rd_vld_o == 1'b1, {tag, " R9 valid"}, int'(rd_vld_o), 1);
        chk(int'(rd_data_o) == exp_d, {tag, " R1 R2 data"}, int'(rd_data_o), exp_d);
        chk(int'(rd_ch_o) == c && int'(rd_smp_o) == k, {tag, " R3 tags ch*16+smp"},
            int'(rd_ch_o) * 16 + int'(rd_smp_o), c * 16 + k);
        chk(rd_last_o == exp_l, {tag, " R3 last"}, int'(rd_last_o), int'(exp_l));
        @(negedge clk);
      end
    end
    rd_rdy_i = 1'b0;
  endtask

  initial begin
    for (int cyc = 0; cyc < 50000; cyc++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int na, nb, nc, nd, ne;
    rst_ni = 1'b0; init_i = 1'b0; smp_en_i = 1'b0; l1a_i = 1'b0; rd_rdy_i = 1'b0;
    smp_data_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_vld_o == 1'b0, "R8 valid after reset", int'(rd_vld_o), 0);
    chk(busy_o == 1'b0, "R8 busy after reset", int'(busy_o), 0);
    chk(drop_cnt_o == '0, "R8 drop count after reset", int'(drop_cnt_o), 0);

    init_i = 1'b1; @(negedge clk); init_i = 1'b0; n = 0;
    strobes(8);

    // single event with stall
    na = n; accept();
    chk(busy_o == 1'b1, "R5 busy after accept", int'(busy_o), 1);
    strobes(WIN - 1);
    chk(busy_o == 1'b1, "R5 busy during capture", int'(busy_o), 1);
    chk(rd_vld_o == 1'b0, "R9 no valid before capture ends", int'(rd_vld_o), 0);
    strobe();
    chk(busy_o == 1'b0, "R5 busy released after window", int'(busy_o), 0);
    chk(rd_vld_o == 1'b1, "R9 valid after window", int'(rd_vld_o), 1);
    repeat (2) begin
      @(negedge clk);
      chk(int'(rd_data_o) == xval(na - LAT, 0) && rd_smp_o == '0,
          "R9 word held under stall", int'(rd_data_o), xval(na - LAT, 0));
    end
    read_event(na, "event A");
    chk(rd_vld_o == 1'b0, "R4 buffer released", int'(rd_vld_o), 0);

    // fill every buffer, drop during capture and while full
    nb = n; accept(); strobes(2);
    accept();
    chk(int'(drop_cnt_o) == 1, "R6 drop during capture", int'(drop_cnt_o), 1);
    strobes(WIN - 2);
    nc = n; accept(); strobes(WIN);
    nd = n; accept(); strobes(WIN);
    chk(busy_o == 1'b1, "R5 busy when all buffers full", int'(busy_o), 1);
    accept();
    chk(int'(drop_cnt_o) == 2, "R6 drop while full", int'(drop_cnt_o), 2);
    strobes(3);
    chk(busy_o == 1'b1, "R6 dropped accept starts nothing", int'(busy_o), 1);
    read_event(nb, "event B R4 R6");
    chk(busy_o == 1'b0, "R4 R5 busy clears after one release", int'(busy_o), 0);
    read_event(nc, "event C R4 R6");
    read_event(nd, "event D R4 R6");
    chk(rd_vld_o == 1'b0, "R4 all events drained", int'(rd_vld_o), 0);

    // sweep accept phase over every ring position
    for (int i = 0; i < DEPTH; i++) begin
      ne = n; accept(); strobes(WIN);
      read_event(ne, "phase sweep R2");
      strobes(2);
    end

    // initialize with a held event and a capture in progress
    accept(); strobes(WIN);
    accept(); strobes(2);
    init_i = 1'b1; @(negedge clk); init_i = 1'b0; n = 0;
    chk(busy_o == 1'b0, "R7 busy cleared by init", int'(busy_o), 0);
    chk(rd_vld_o == 1'b0, "R7 events discarded by init", int'(rd_vld_o), 0);
    chk(drop_cnt_o == '0, "R7 drop count cleared by init", int'(drop_cnt_o), 0);
    strobes(LAT);
    ne = n; accept(); strobes(WIN);
    read_event(ne, "after init R7");
    chk(rd_vld_o == 1'b0, "R7 only new event present", int'(rd_vld_o), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule